// File: doc/BRIEF.md
# Effective Address Calculation Unit

This unit turns one decoded operand specifier into an operand location. Each request carries an addressing mode, a 32-bit instruction field, a flag that marks the field as a short 8-bit displacement, a base register value, an index register value, a two-bit scale select and the address of the next instruction. The unit returns either a 32-bit effective address or, for the modes that need no memory access, the operand value itself. A result is announced by a one-cycle `done` pulse. The result outputs hold their value until the next result replaces them.

Most modes finish one clock after `start`. Memory-indirect mode instead reads a pointer word through a synchronous read port: one cycle after `start` the read is issued, the memory answers one cycle later, and that word becomes the effective address. While this read is in progress the unit reports `busy` and ignores new requests. All address arithmetic wraps modulo 2^32. When the short flag is set, the low 8 bits of the field are sign-extended and used as the displacement or immediate value.

Top module: `ea_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `done`, `busy`, `mem_rd_en`, `ea_valid` and `operand_valid` are low, and `ea` and `operand` are zero.
- R2: Immediate mode (mode 0) returns `operand` equal to the field, or to the sign-extended low 8 bits when `disp_short` is 1. `operand_valid` is 1, `ea_valid` is 0 and `ea` is zero.
- R3: Direct mode (mode 1) returns `ea` equal to the full 32-bit field, with `ea_valid` 1.
- R4: Register mode (mode 2) returns `operand` equal to `base_val`, with `operand_valid` 1, `ea_valid` 0 and `ea` zero.
- R5: Register-indirect mode (mode 3) returns `ea` equal to `base_val`.
- R6: Memory-indirect mode (mode 4) asserts `mem_rd_en` for exactly one cycle, one cycle after `start`, with `mem_rd_addr` equal to the field. `done` follows three cycles after `start`, and `ea` then equals the word the memory returned.
- R7: Displacement mode (mode 5) returns `ea` = `base_val` + displacement, modulo 2^32.
- R8: Scaled mode (mode 6) returns `ea` = `base_val` + `index_val` × 2^`scale_sel` + displacement, where `scale_sel` values 0, 1, 2 and 3 mean ×1, ×2, ×4 and ×8.
- R9: Relative mode (mode 7) returns `ea` = `next_pc` + signed displacement. For example, next address 0x39 with short field 0xEF gives 0x28.
- R10: Every mode except mode 4 raises `done` for one cycle, one cycle after `start`. Back-to-back starts give back-to-back results.
- R11: A `start` while `busy` is high is ignored. It produces no extra `done`, and it does not alter the pending memory-indirect result.
- R12: Each `done` has exactly one of `ea_valid` and `operand_valid` high, and every output other than `done` holds its value between results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted only when not busy |
| mode | input | 3 | Addressing mode code 0..7 |
| field | input | 32 | Instruction address, displacement or immediate field |
| disp_short | input | 1 | 1: use sign-extended field[7:0] as displacement/immediate |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| scale_sel | input | 2 | Index shift 0..3 |
| next_pc | input | 32 | Address of the next instruction |
| mem_rd_en | output | 1 | Pointer read request |
| mem_rd_addr | output | 32 | Pointer read address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the request |
| busy | output | 1 | Memory-indirect sequence in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 32 | Effective address |
| ea_valid | output | 1 | `ea` is meaningful |
| operand | output | 32 | Operand value for immediate and register modes |
| operand_valid | output | 1 | `operand` is meaningful |

## Verification
Results for modes other than 4 are due on the clock after the accepted `start`. For mode 4 the read strobe is due one clock after `start` and the result two clocks after that. The bench records the cycle of each accepted request and queues the expected result with its due cycle. On every clock it compares `done`, `mem_rd_en` and, when a result is due, all result outputs, so a result that arrives a cycle early or late is reported. Requests issued while the reference marks the unit busy queue nothing, so any stray `done` is flagged.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int EA_AW = 32;
  localparam int EA_SW = 8;
  localparam int EA_MODE_W = 3;

  typedef enum logic [EA_MODE_W-1:0] {
    M_IMM  = 3'd0,
    M_DIR  = 3'd1,
    M_REG  = 3'd2,
    M_RIND = 3'd3,
    M_MIND = 3'd4,
    M_DISP = 3'd5,
    M_BSID = 3'd6,
    M_REL  = 3'd7
  } ea_mode_e;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int AW  = EA_AW,
  parameter int SW  = EA_SW,
  parameter int SCW = 2
) (
  input  ea_mode_e          mode,
  input  logic [AW-1:0]     field,
  input  logic              disp_short,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     index_val,
  input  logic [SCW-1:0]    scale_sel,
  input  logic [AW-1:0]     next_pc,
  output logic [AW-1:0]     ea,
  output logic              ea_ok,
  output logic [AW-1:0]     opnd,
  output logic              opnd_ok,
  output logic              need_mem
);
  logic [AW-1:0] disp;
  logic [AW-1:0] stage [SCW+1];

  assign disp = disp_short ? {{(AW-SW){field[SW-1]}}, field[SW-1:0]} : field;

  // barrel shifter for the index, one stage per scale-select bit
  assign stage[0] = index_val;
  for (genvar g = 0; g < SCW; g++) begin : g_shift
    assign stage[g+1] = scale_sel[g] ? (stage[g] << (1 << g)) : stage[g];
  end

  always_comb begin
    ea       = '0;
    ea_ok    = 1'b0;
    opnd     = '0;
    opnd_ok  = 1'b0;
    need_mem = 1'b0;
    unique case (mode)
      M_IMM:  begin opnd = disp;     opnd_ok = 1'b1; end
      M_DIR:  begin ea = field;      ea_ok = 1'b1; end
      M_REG:  begin opnd = base_val; opnd_ok = 1'b1; end
      M_RIND: begin ea = base_val;   ea_ok = 1'b1; end
      M_MIND: need_mem = 1'b1;
      M_DISP: begin ea = base_val + disp; ea_ok = 1'b1; end
      M_BSID: begin ea = base_val + stage[SCW] + disp; ea_ok = 1'b1; end
      M_REL:  begin ea = next_pc + disp; ea_ok = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_mem,
  output logic load_calc,
  output logic load_ptr,
  output logic capture,
  output logic rd_en,
  output logic busy,
  output logic done
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WT} st_e;
  st_e  st_q, st_d;
  logic done_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (start && need_mem) st_d = S_RD;
      S_RD:    st_d = S_WT;
      S_WT:    st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  assign load_calc = start && (st_q == S_IDLE) && !need_mem;
  assign load_ptr  = start && (st_q == S_IDLE) && need_mem;
  assign capture   = (st_q == S_WT);
  assign rd_en     = (st_q == S_RD);
  assign busy      = (st_q != S_IDLE);
  assign done_d    = load_calc || capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= done_d;
    end
  end

  // R6: read strobe lasts one cycle and is followed by the wait cycle
  a_r6_read_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (!rd_en && busy));
  // R6: the result strobe follows the wait cycle
  a_r6_done_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_WT) |=> done);
  // R11: no result may appear while the pointer read is outstanding
  a_r11_quiet_while_reading: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !done);
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int AW  = EA_AW,
  parameter int SW  = EA_SW,
  parameter int SCW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [EA_MODE_W-1:0] mode,
  input  logic [AW-1:0]        field,
  input  logic                 disp_short,
  input  logic [AW-1:0]        base_val,
  input  logic [AW-1:0]        index_val,
  input  logic [SCW-1:0]       scale_sel,
  input  logic [AW-1:0]        next_pc,
  output logic                 mem_rd_en,
  output logic [AW-1:0]        mem_rd_addr,
  input  logic [AW-1:0]        mem_rd_data,
  output logic                 busy,
  output logic                 done,
  output logic [AW-1:0]        ea,
  output logic                 ea_valid,
  output logic [AW-1:0]        operand,
  output logic                 operand_valid
);
  logic [AW-1:0] c_ea, c_op;
  logic          c_ea_ok, c_op_ok, need_mem;
  logic          load_calc, load_ptr, capture;

  logic [AW-1:0] ea_q, ea_d, op_q, op_d, ptr_q, ptr_d;
  logic          eaok_q, eaok_d, opok_q, opok_d;

  ea_calc #(.AW(AW), .SW(SW), .SCW(SCW)) u_calc (
    .mode      (ea_mode_e'(mode)),
    .field     (field),
    .disp_short(disp_short),
    .base_val  (base_val),
    .index_val (index_val),
    .scale_sel (scale_sel),
    .next_pc   (next_pc),
    .ea        (c_ea),
    .ea_ok     (c_ea_ok),
    .opnd      (c_op),
    .opnd_ok   (c_op_ok),
    .need_mem  (need_mem)
  );

  ea_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .need_mem (need_mem),
    .load_calc(load_calc),
    .load_ptr (load_ptr),
    .capture  (capture),
    .rd_en    (mem_rd_en),
    .busy     (busy),
    .done     (done)
  );

  always_comb begin
    ea_d   = ea_q;
    eaok_d = eaok_q;
    op_d   = op_q;
    opok_d = opok_q;
    ptr_d  = ptr_q;
    if (load_ptr) ptr_d = field;
    if (load_calc) begin
      ea_d = c_ea;  eaok_d = c_ea_ok;
      op_d = c_op;  opok_d = c_op_ok;
    end else if (capture) begin
      ea_d = mem_rd_data; eaok_d = 1'b1;
      op_d = '0;          opok_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q   <= '0;
      eaok_q <= 1'b0;
      op_q   <= '0;
      opok_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      ea_q   <= ea_d;
      eaok_q <= eaok_d;
      op_q   <= op_d;
      opok_q <= opok_d;
      ptr_q  <= ptr_d;
    end
  end

  assign ea            = ea_q;
  assign ea_valid      = eaok_q;
  assign operand       = op_q;
  assign operand_valid = opok_q;
  assign mem_rd_addr   = ptr_q;

  // R12: a result names either an address or an operand, never both
  a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ea_valid != operand_valid));
  // R2/R4: operand results carry no address
  a_r2_no_ea_with_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (done && operand_valid) |-> (ea == '0));
  // R6: pointer address is the field of the request accepted one cycle earlier
  a_r6_ptr_from_field: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (mem_rd_addr == $past(field)));
  // R12: results hold between strobes
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (!done || 1'b1) && ($stable(ea) || done));
endmodule

// File: tb/test_ea_unit.sv
`timescale 1ns/1ps
module test_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] field = '0;
  logic        disp_short = 1'b0;
  logic [31:0] base_val = '0, index_val = '0, next_pc = '0;
  logic [1:0]  scale_sel = '0;
  logic        mem_rd_en, busy, done, ea_valid, operand_valid;
  logic [31:0] mem_rd_addr, ea, operand;
  logic [31:0] mem_q = '0;

  always #2.5 clk = ~clk;

  ea_unit i_ea_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .field(field),
    .disp_short(disp_short), .base_val(base_val), .index_val(index_val),
    .scale_sel(scale_sel), .next_pc(next_pc), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_q), .busy(busy), .done(done),
    .ea(ea), .ea_valid(ea_valid), .operand(operand), .operand_valid(operand_valid)
  );

  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A5A_C3C3;
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_q <= memfn(mem_rd_addr);

  typedef struct {
    int          due;
    logic [31:0] ea;
    logic        eav;
    logic [31:0] op;
    logic        opv;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   n_cmp = 0, n_bad = 0;
  int   busy_until = 0;
  int   rd_cyc = -1;
  logic [31:0] rd_addr = '0;
  bit   checking = 0, finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got 0x%08h expected 0x%08h", req, cyc, act, expv);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) if (checking) begin
    check("R6 read strobe", {31'b0, mem_rd_en}, {31'b0, cyc == rd_cyc});
    if (cyc == rd_cyc) check("R6 read address", mem_rd_addr, rd_addr);
    if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      check({exp_q[0].req, " R10 done"}, {31'b0, done}, 32'd1);
      check({exp_q[0].req, " ea"}, ea, exp_q[0].ea);
      check({exp_q[0].req, " R12 ea_valid"}, {31'b0, ea_valid}, {31'b0, exp_q[0].eav});
      check({exp_q[0].req, " operand"}, operand, exp_q[0].op);
      check({exp_q[0].req, " R12 operand_valid"}, {31'b0, operand_valid}, {31'b0, exp_q[0].opv});
      void'(exp_q.pop_front());
    end else begin
      check("R10/R11 no unexpected done", {31'b0, done}, 32'd0);
    end
  end

  function automatic logic [31:0] sx(input logic [31:0] f, input logic s);
    return s ? 32'(signed'(f[7:0])) : f;
  endfunction

  task automatic issue(input logic [2:0] m, input logic [31:0] f, input logic s,
                       input logic [31:0] b, input logic [31:0] x, input logic [1:0] sc,
                       input logic [31:0] pc, input string req);
    exp_t e;
    longint unsigned sum;
    @(negedge clk);
    start = 1; mode = m; field = f; disp_short = s;
    base_val = b; index_val = x; scale_sel = sc; next_pc = pc;
    if (cyc >= busy_until) begin
      e.req = req; e.ea = '0; e.eav = 0; e.op = '0; e.opv = 0; e.due = cyc + 1;
      case (m)
        3'd0: begin e.op = sx(f, s); e.opv = 1; end
        3'd1: begin e.ea = f; e.eav = 1; end
        3'd2: begin e.op = b; e.opv = 1; end
        3'd3: begin e.ea = b; e.eav = 1; end
        3'd4: begin
          e.ea = memfn(f); e.eav = 1; e.due = cyc + 3;
          rd_cyc = cyc + 1; rd_addr = f; busy_until = cyc + 3;
        end
        3'd5: begin sum = longint'(b) + longint'(sx(f, s)); e.ea = sum[31:0]; e.eav = 1; end
        3'd6: begin
          sum = longint'(b) + longint'(x) * (longint'(1) << sc) + longint'(sx(f, s));
          e.ea = sum[31:0]; e.eav = 1;
        end
        default: begin sum = longint'(pc) + longint'(sx(f, s)); e.ea = sum[31:0]; e.eav = 1; end
      endcase
      exp_q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk); start = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset done", {31'b0, done}, 0);
    check("R1 reset busy", {31'b0, busy}, 0);
    check("R1 reset rd", {31'b0, mem_rd_en}, 0);
    check("R1 reset ea", ea, 0);
    check("R1 reset valids", {30'b0, ea_valid, operand_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", {29'b0, done, ea_valid, operand_valid}, 0);
    checking = 1;

    issue(3'd0, 32'h1234_5678, 0, 0, 0, 0, 0, "R2 imm long");
    issue(3'd0, 32'h0000_0080, 1, 0, 0, 0, 0, "R2 imm short neg");
    issue(3'd1, 32'hDEAD_BEEF, 1, 0, 0, 0, 0, "R3 direct");
    issue(3'd2, 32'hFF, 0, 32'hCAFE_0001, 0, 0, 0, "R4 register");
    issue(3'd3, 0, 0, 32'h0040_4004, 0, 0, 0, "R5 reg indirect");
    idle(2);
    issue(3'd4, 32'h0040_4000, 0, 0, 0, 0, 0, "R6 mem indirect");
    issue(3'd1, 32'h1111_1111, 0, 0, 0, 0, 0, "R11 ignored start");
    issue(3'd0, 32'h2222_2222, 0, 0, 0, 0, 0, "R11 ignored start");
    idle(3);
    issue(3'd5, 32'h20, 0, 32'hFFFF_FFF0, 0, 0, 0, "R7 disp wrap");
    issue(3'd5, 32'hFE, 1, 32'h0000_1000, 0, 0, 0, "R7 disp short neg");
    for (int s = 0; s < 4; s++)
      issue(3'd6, 32'h10, 0, 32'h0040_4000, 32'h3, 2'(s), 0, "R8 scaled");
    issue(3'd6, 32'hF0, 1, 32'h100, 32'h8000_0001, 2'd3, 0, "R8 scaled wrap");
    issue(3'd7, 32'hEF, 1, 0, 0, 0, 32'h39, "R9 relative back");
    issue(3'd7, 32'h100, 0, 0, 0, 0, 32'h1000, "R9 relative fwd");
    issue(3'd4, 32'h0000_ABCD, 0, 0, 0, 0, 0, "R6 mem indirect 2");
    idle(5);
    check("R12 hold ea", ea, memfn(32'h0000_ABCD));
    checking = 0;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end
endmodule